// File: doc/BRIEF.md
# Audio Channel FIFO Interrupt Logic

This block is one transmit/receive channel of a serial audio controller. It holds a receive FIFO, which the slot side fills and software drains, and a transmit FIFO, which software fills and the slot side drains. Each FIFO runs in one of two modes. In deep mode it uses `DEPTH` entries and its interrupt source follows a half-depth threshold. In single mode it shrinks to one entry, and its interrupt source follows whether that entry holds a word.

Both interrupt sources can be read as raw status. Each source also has its own enable bit. The enabled sources appear as masked status and are ORed into one active-high interrupt line. Sticky flags record a push into a full FIFO (overrun) and a pop from an empty FIFO (underrun). Software clears these flags by writing 1 to them.

The register port decodes a 3-bit word address. Read data is combinational from the current state. Every register side effect (pop, push, control update, flag clear) takes place at the rising clock edge of the access cycle.

Top module: `chan_irq_ctl`

## Requirements
- R1: After reset both FIFOs are empty and in single mode. Both enables are 0, all flags are 0 and `irq` is 0. The raw status word therefore reads 0x02, because the transmit source is set.
- R2: Register addresses:
  - 0, data: a write pushes `reg_wdata[WIDTH-1:0]` into the transmit FIFO. A read returns the receive head, zero-extended, and pops it.
  - 1, control: bit0 selects receive deep mode, bit1 transmit deep mode, bit2 is the receive enable and bit3 the transmit enable.
  - 2, raw status: bit0 receive source, bit1 transmit source, bit2 receive overrun, bit3 receive underrun, bit4 transmit overrun, bit5 transmit underrun.
  - 3, masked status: bit0 receive, bit1 transmit.
  - 4, levels: receive count in bits [CW-1:0], transmit count in bits [16+CW-1:16].
  - All other addresses read 0, and writes to them have no effect.
- R3: A FIFO holds `DEPTH` words in deep mode and one word in single mode, and words leave it in arrival order. A push into a full FIFO is dropped, leaves its contents unchanged and sets that FIFO's overrun flag.
- R4: A pop from an empty FIFO returns 0 and sets that FIFO's underrun flag. While the transmit FIFO is empty, `tx_word` is 0.
- R5: In deep mode the receive source is 1 exactly while the receive count is at least `DEPTH/2`.
- R6: In single mode a single received word sets the receive source, and a single data read clears it.
- R7: In deep mode the transmit source is 1 exactly while the transmit count is at most `DEPTH/2`.
- R8: In single mode the transmit source is 1 while the entry is empty, and a single data write clears it.
- R9: Each masked status bit is the raw source ANDed with its enable bit. `irq` is the OR of the masked bits.
- R10: A control write that changes a FIFO's mode bit empties that FIFO and leaves the other FIFO as it was.
- R11: Flags stay set until software writes 1 to their bit at address 2. If a clear and a new event arrive in the same cycle, the flag stays set.
- R12: A push that arrives in the same cycle as a pop is judged on the count before that cycle. So at full, the pop succeeds and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| rx_push | input | 1 | Slot side: push a received word |
| rx_word | input | WIDTH | Slot side: received word |
| tx_pop | input | 1 | Slot side: pop the word to transmit |
| tx_word | output | WIDTH | Slot side: transmit head, 0 when empty |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The single-mode clear assertions assume that no slot push lands on the receive FIFO in the same cycle as the data read they watch. They also assume that the mode bits are not rewritten during the data access, which the address decode already guarantees. The sticky-flag assertion only assumes that clears arrive through address 2. The directed part of the stimulus keeps to these conditions. The mixed random part may collide a pop, a push and a clear in any combination, and the behavioural queue model resolves each collision by the same-cycle rules given in R11 and R12.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_CTRL = 3'd1;
   localparam logic [2:0] A_RAW  = 3'd2;
   localparam logic [2:0] A_MSK  = 3'd3;
   localparam logic [2:0] A_LVL  = 3'd4;

   localparam int C_RX_DEEP = 0;
   localparam int C_TX_DEEP = 1;
   localparam int C_RX_IE   = 2;
   localparam int C_TX_IE   = 3;

   localparam int S_RX_OVR = 2;
   localparam int S_TX_UDR = 5;
   localparam int LVL_TX_LSB = 16;
endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 20,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             deep,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             push_drop,
   output logic             pop_miss
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cap;
   logic             full, empty, do_push, do_pop;

   assign cap       = deep ? CW'(DEPTH) : CW'(1);
   assign full      = (count == cap);
   assign empty     = (count == '0);
   assign do_push   = push & ~full  & ~flush;
   assign do_pop    = pop  & ~empty & ~flush;
   assign push_drop = push & full   & ~flush;
   assign pop_miss  = pop  & empty  & ~flush;
   assign head      = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= cap); // R3
   AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(count)); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0)); // R10
endmodule

// File: rtl/chan_irq_src.sv
module chan_irq_src #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH) + 1,
   localparam int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_deep,
   input  logic            tx_deep,
   input  logic [CW-1:0]   rx_cnt,
   input  logic [CW-1:0]   tx_cnt,
   input  logic [NSRC-1:0] ie,
   output logic [NSRC-1:0] raw,
   output logic [NSRC-1:0] masked,
   output logic            irq
);
   localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

   assign raw[0] = rx_deep ? (rx_cnt >= HALF) : (rx_cnt != '0);
   assign raw[1] = tx_deep ? (tx_cnt <= HALF) : (tx_cnt == '0);

   for (genvar i = 0; i < NSRC; i++) begin : g_mask
      assign masked[i] = raw[i] & ie[i];
   end

   assign irq = |masked;

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie != '0)); // R9
endmodule

// File: rtl/chan_irq_ctl.sv
module chan_irq_ctl
   import chan_irq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int WIDTH = 20,
   parameter int DW    = 32,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic             rx_push,
   input  logic [WIDTH-1:0] rx_word,
   input  logic             tx_pop,
   output logic [WIDTH-1:0] tx_word,
   output logic             irq
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("chan_irq_ctl: DEPTH must be a power of two >= 2");
   end
   if (WIDTH > DW) begin : g_bad_width
      $error("chan_irq_ctl: WIDTH must not exceed DW");
   end
   if (DW < LVL_TX_LSB + CW || CW > LVL_TX_LSB) begin : g_bad_level
      $error("chan_irq_ctl: DW too narrow for the level register");
   end

   logic [3:0]       ctrl_q;
   logic [3:0]       flags_q, flag_set, flag_clr;
   logic             wr_data, rd_data, wr_ctrl, wr_raw;
   logic             rx_flush, tx_flush;
   logic [WIDTH-1:0] rx_head;
   logic [CW-1:0]    rx_cnt, tx_cnt;
   logic             rx_drop, rx_miss, tx_drop, tx_miss;
   logic [1:0]       raw_src, msk_src;
   logic             unused_wd;

   assign unused_wd = ^reg_wdata;
   assign wr_data   = reg_wr && (reg_addr == A_DATA);
   assign rd_data   = reg_rd && (reg_addr == A_DATA);
   assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
   assign wr_raw    = reg_wr && (reg_addr == A_RAW);
   assign rx_flush  = wr_ctrl && (reg_wdata[C_RX_DEEP] != ctrl_q[C_RX_DEEP]);
   assign tx_flush  = wr_ctrl && (reg_wdata[C_TX_DEEP] != ctrl_q[C_TX_DEEP]);

   chan_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .deep(ctrl_q[C_RX_DEEP]), .flush(rx_flush),
      .push(rx_push), .push_data(rx_word), .pop(rd_data),
      .head(rx_head), .count(rx_cnt), .push_drop(rx_drop), .pop_miss(rx_miss));

   chan_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .deep(ctrl_q[C_TX_DEEP]), .flush(tx_flush),
      .push(wr_data), .push_data(reg_wdata[WIDTH-1:0]), .pop(tx_pop),
      .head(tx_word), .count(tx_cnt), .push_drop(tx_drop), .pop_miss(tx_miss));

   chan_irq_src #(.DEPTH(DEPTH)) u_irq_src (
      .clk(clk), .rst_n(rst_n),
      .rx_deep(ctrl_q[C_RX_DEEP]), .tx_deep(ctrl_q[C_TX_DEEP]),
      .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
      .ie({ctrl_q[C_TX_IE], ctrl_q[C_RX_IE]}),
      .raw(raw_src), .masked(msk_src), .irq(irq));

   assign flag_set = {tx_miss, tx_drop, rx_miss, rx_drop};
   assign flag_clr = wr_raw ? reg_wdata[S_TX_UDR:S_RX_OVR] : 4'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flags_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[3:0];
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_DATA: reg_rdata = DW'(rx_head);
         A_CTRL: reg_rdata[3:0] = ctrl_q;
         A_RAW:  reg_rdata[5:0] = {flags_q, raw_src};
         A_MSK:  reg_rdata[1:0] = msk_src;
         A_LVL: begin
            reg_rdata[CW-1:0]            = rx_cnt;
            reg_rdata[LVL_TX_LSB +: CW]  = tx_cnt;
         end
         default: reg_rdata = '0;
      endcase
   end

   AST_RX_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[C_RX_DEEP] && rx_cnt == CW'(1) && rd_data && !rx_push) |=> !raw_src[0]); // R6
   AST_TX_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[C_TX_DEEP] && tx_cnt == '0 && wr_data && !tx_pop) |=> !raw_src[1]); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[0] && !(wr_raw && reg_wdata[S_RX_OVR])) |=> flags_q[0]); // R11
endmodule

// File: tb/chan_irq_ctl_bench.sv
`timescale 1ns/1ps
module chan_irq_ctl_bench;
   localparam int DEPTH = 8;
   localparam int WIDTH = 20;
   localparam int DW    = 32;
   localparam int HALF  = DEPTH / 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [DW-1:0]    reg_wdata = '0;
   logic [DW-1:0]    reg_rdata;
   logic             rx_push = 1'b0;
   logic [WIDTH-1:0] rx_word = '0;
   logic             tx_pop = 1'b0;
   logic [WIDTH-1:0] tx_word;
   logic             irq;

   always #4 clk = ~clk;

   chan_irq_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DW(DW)) u_chan_irq_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_push(rx_push), .rx_word(rx_word), .tx_pop(tx_pop),
      .tx_word(tx_word), .irq(irq));

   int n_vec = 0, n_bad = 0;

   // behavioural model
   logic [WIDTH-1:0] rxq[$], txq[$];
   bit m_rxd = 0, m_txd = 0, m_rxie = 0, m_txie = 0;
   bit [3:0] m_flg = '0; // rx ovr, rx udr, tx ovr, tx udr

   function automatic logic [1:0] m_src();
      logic rs, ts;
      rs = m_rxd ? (rxq.size() >= HALF) : (rxq.size() >= 1);
      ts = m_txd ? (txq.size() <= HALF) : (txq.size() == 0);
      return {ts, rs};
   endfunction

   function automatic logic [DW-1:0] m_rdata(input logic [2:0] a);
      logic [DW-1:0] v;
      v = '0;
      case (a)
         3'd0: if (rxq.size() > 0) v[WIDTH-1:0] = rxq[0];
         3'd1: v[3:0] = {m_txie, m_rxie, m_txd, m_rxd};
         3'd2: v[5:0] = {m_flg, m_src()};
         3'd3: v[1:0] = m_src() & {m_txie, m_rxie};
         3'd4: begin
            v[15:0]  = 16'(rxq.size());
            v[31:16] = 16'(txq.size());
         end
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic m_step(input logic wr, input logic rd, input logic [2:0] a,
                         input logic [DW-1:0] wd, input logic rxp,
                         input logic [WIDTH-1:0] rxw, input logic txp);
      bit rxfl, txfl, full, empty, pop, push;
      bit [3:0] set, clr;
      set = '0;
      clr = (wr && a == 3'd2) ? wd[5:2] : 4'b0;
      rxfl = wr && a == 3'd1 && (wd[0] != m_rxd);
      txfl = wr && a == 3'd1 && (wd[1] != m_txd);
      if (rxfl) rxq.delete();
      else begin
         pop = rd && a == 3'd0; push = rxp;
         full = rxq.size() >= (m_rxd ? DEPTH : 1); empty = rxq.size() == 0;
         if (pop && !empty) void'(rxq.pop_front());
         if (pop && empty) set[1] = 1;
         if (push && !full) rxq.push_back(rxw);
         if (push && full) set[0] = 1;
      end
      if (txfl) txq.delete();
      else begin
         pop = txp; push = wr && a == 3'd0;
         full = txq.size() >= (m_txd ? DEPTH : 1); empty = txq.size() == 0;
         if (pop && !empty) void'(txq.pop_front());
         if (pop && empty) set[3] = 1;
         if (push && !full) txq.push_back(wd[WIDTH-1:0]);
         if (push && full) set[2] = 1;
      end
      m_flg = (m_flg & ~clr) | set;
      if (wr && a == 3'd1) {m_txie, m_rxie, m_txd, m_rxd} = wd[3:0];
   endtask

   task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                      input logic [DW-1:0] wd, input logic rxp,
                      input logic [WIDTH-1:0] rxw, input logic txp,
                      input string tag);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      rx_push = rxp; rx_word = rxw; tx_pop = txp;
      #1;
      chk(tag, "reg_rdata", reg_rdata, m_rdata(a));
      chk(tag, "irq", DW'(irq), DW'(m_src() & {m_txie, m_rxie}) != 0 ? 1 : 0);
      chk(tag, "tx_word", DW'(tx_word), txq.size() > 0 ? DW'(txq[0]) : '0);
      @(posedge clk);
      m_step(wr, rd, a, wd, rxp, rxw, txp);
      @(negedge clk);
   endtask

   task automatic rreg(input logic [2:0] a, input string tag);
      cyc(0, 1, a, '0, 0, '0, 0, tag);
   endtask
   task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
      cyc(1, 0, a, d, 0, '0, 0, tag);
   endtask
   task automatic push_rx(input logic [WIDTH-1:0] w, input string tag);
      cyc(0, 0, 3'd0, '0, 1, w, 0, tag);
   endtask
   task automatic pop_tx(input string tag);
      cyc(0, 0, 3'd0, '0, 0, '0, 1, tag);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rreg(3'd2, "R1"); rreg(3'd1, "R1"); rreg(3'd4, "R1"); rreg(3'd3, "R1");
      // R6 single-mode receive
      push_rx(20'hA1111, "R6"); rreg(3'd2, "R6"); rreg(3'd0, "R6"); rreg(3'd2, "R6");
      // R3 single-mode overrun
      push_rx(20'hB1111, "R3"); push_rx(20'hB2222, "R3");
      rreg(3'd0, "R3"); rreg(3'd2, "R3");
      // R11 write-1 clear
      wreg(3'd2, 32'h4, "R11"); rreg(3'd2, "R11");
      // R4 underruns on both FIFOs
      rreg(3'd0, "R4"); pop_tx("R4"); rreg(3'd2, "R4");
      // R8 single-mode transmit
      wreg(3'd0, 32'hC1111, "R8"); rreg(3'd2, "R8"); pop_tx("R8"); rreg(3'd2, "R8");
      wreg(3'd2, 32'h3C, "R11"); rreg(3'd2, "R11");
      // R9 masking and combining
      wreg(3'd1, 32'h8, "R9"); rreg(3'd3, "R9");
      wreg(3'd0, 32'hD1111, "R9"); rreg(3'd3, "R9"); pop_tx("R9");
      // R5 deep-mode receive threshold
      wreg(3'd1, 32'h5, "R5");
      for (int i = 0; i < HALF - 1; i++) push_rx(WIDTH'(32'h50 + i), "R5");
      rreg(3'd2, "R5");
      push_rx(20'h5FFFF, "R5"); rreg(3'd3, "R5");
      rreg(3'd0, "R5"); rreg(3'd2, "R5");
      // R3 deep capacity and order
      for (int i = 0; i < DEPTH - HALF + 2; i++) push_rx(WIDTH'(32'h300 + i), "R3");
      rreg(3'd4, "R3"); rreg(3'd2, "R3");
      // R12 push and pop together at full
      cyc(0, 1, 3'd0, '0, 1, 20'hEEEEE, 0, "R12"); rreg(3'd4, "R12");
      // R11 set wins over clear
      push_rx(20'h77777, "R11");
      cyc(1, 0, 3'd2, 32'h4, 1, 20'h88888, 0, "R11"); rreg(3'd2, "R11");
      // R10 flush of one FIFO only
      wreg(3'd0, 32'hE1111, "R10");
      wreg(3'd1, 32'h4, "R10"); rreg(3'd4, "R10"); rreg(3'd0, "R10");
      // R7 deep-mode transmit threshold
      wreg(3'd1, 32'hA, "R7"); rreg(3'd2, "R7");
      for (int i = 0; i < HALF; i++) wreg(3'd0, 32'h700 + i, "R7");
      rreg(3'd3, "R7");
      wreg(3'd0, 32'h7FF, "R7"); rreg(3'd3, "R7");
      pop_tx("R7"); rreg(3'd3, "R7");
      for (int i = 0; i < DEPTH; i++) pop_tx("R3");
      // R2 unused addresses and mixed traffic
      wreg(3'd5, 32'hFFFF, "R2"); rreg(3'd5, "R2"); rreg(3'd7, "R2");
      for (int i = 0; i < 400; i++) begin
         logic [2:0] a;
         logic [DW-1:0] d;
         a = 3'($urandom_range(0, 5));
         d = (a == 3'd1) ? DW'($urandom_range(0, 15)) : DW'($urandom);
         cyc(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), a, d,
             1'($urandom_range(0, 1)), WIDTH'($urandom), 1'($urandom_range(0, 2) == 0),
             "R12");
      end
      summary();
      $finish;
   end
endmodule